// File: doc/BRIEF.md
# Fractional-Rate Precision Time Counter

This block keeps a 64-bit precision time count that advances at a nominal 25 MHz, so one count is 40 ns. The system clock can run at any frequency. On every system clock edge a 32-bit fractional accumulator adds a programmable step value. Each carry out of that accumulator advances the time count by one. Software sets the step to 25,000,000 × 2^32 divided by the system clock frequency, which makes the average carry rate exactly 25 MHz.

A small register port lets software do three things:
- set the step;
- read the time as two 32-bit words, with the high word kept coherent with the low word that was read;
- load a new time.

A load stages the low word first. Writing the high word then places both words into the counter in one step and restarts the fractional phase. The running count is also presented on a wide output bus, so that a capture unit for transmit and receive events can latch it.

Top module: `ptp_frac_clock`

## Requirements
- R1: After a synchronous reset the time count is zero, the read-valid output is low, and the step register holds the nominal value derived from the parameters (0x40000000 for a 100 MHz system clock).
- R2: On every clock edge the accumulator becomes (accumulator + step) mod 2^32. The time count rises by one exactly on the edges where that sum reaches 2^32. After k edges that follow a load, the count is therefore the loaded value + floor(k × step / 2^32).
- R3: A step of zero freezes the time count.
- R4: A step of 0xFFFFFFFF advances the count on every edge after a load except the first.
- R5: A write to register address 1 (time low word) only stages a value and leaves the count untouched. A write to address 2 (time high word) loads {written high word, staged low word} on that edge and clears the accumulator.
- R6: A read of address 1 returns the low 32 bits of the count and, on the same edge, copies the high 32 bits into a shadow. A read of address 2 returns that shadow, so that the pair stays coherent when a carry crosses bit 32 between the two reads.
- R7: When the count passes 0xFFFFFFFF_FFFFFFFF it wraps to zero, with no stall and no lost count.
- R8: Read data and the read-valid flag are registered. Both appear on the edge after the one that samples the read request, and read-valid lasts exactly one cycle for each request. Address 0 reads back the step.
- R9: The time output bus always carries the live 64-bit count.
- R10: A new step is used from the edge after the write. Writing it does not clear the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 step, 1 time low, 2 time high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when rd_data is valid |
| time_now | output | 64 | Live time count for the capture unit |

## Verification
The assertions assume that a time load reaches the block only as a high-word write, and that the write and read strobes are never X once reset has been released. They also assume that the step register changes only through an address-0 write. The bench holds every strobe at a known level from time zero. It drives each strobe for exactly one cycle at a falling edge, and it always writes the step before starting a load. This keeps the number of edges since the last load known, so the expected count can be computed from R2 with no model of the accumulator.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  typedef enum logic [1:0] {
    REG_STEP    = 2'd0,
    REG_TIME_LO = 2'd1,
    REG_TIME_HI = 2'd2,
    REG_SPARE   = 2'd3
  } ptp_reg_e;
endpackage

// File: rtl/ptp_frac_acc.sv
module ptp_frac_acc #(
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] step,
  input  logic              clear,
  output logic              carry,
  output logic [FRAC_W-1:0] phase
);
  logic [FRAC_W:0] sum;

  assign sum   = {1'b0, phase} + {1'b0, step};
  assign carry = sum[FRAC_W] & ~clear;

  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else              phase <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/ptp_tick_counter.sv
module ptp_tick_counter #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  input  logic              inc,
  output logic [TIME_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (inc)  count <= count + TIME_W'(1);
  end
endmodule

// File: rtl/ptp_reg_port.sv
module ptp_reg_port
  import ptp_clk_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              FRAC_W   = 32,
  parameter int              TIME_W   = 64,
  parameter logic [FRAC_W-1:0] STEP_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [TIME_W-1:0] time_in,
  output logic [FRAC_W-1:0] step,
  output logic              load,
  output logic [TIME_W-1:0] load_val,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int NWORDS = TIME_W / DATA_W;

  ptp_reg_e              sel;
  logic [DATA_W-1:0]     word   [NWORDS];
  logic [DATA_W-1:0]     stage_lo;
  logic [DATA_W-1:0]     shadow_hi;
  logic [DATA_W-1:0]     rd_next;

  assign sel = ptp_reg_e'(reg_addr);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign word[w] = time_in[w*DATA_W +: DATA_W];
  end

  assign load     = wr_en && (sel == REG_TIME_HI);
  assign load_val = {wr_data, stage_lo};

  always_comb begin
    case (sel)
      REG_STEP:    rd_next = DATA_W'(step);
      REG_TIME_LO: rd_next = word[0];
      REG_TIME_HI: rd_next = shadow_hi;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= STEP_RST;
      stage_lo  <= '0;
      shadow_hi <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      if (wr_en && sel == REG_STEP)    step     <= FRAC_W'(wr_data);
      if (wr_en && sel == REG_TIME_LO) stage_lo <= wr_data;
      if (rd_en && sel == REG_TIME_LO) shadow_hi <= word[NWORDS-1];
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/ptp_frac_clock.sv
module ptp_frac_clock #(
  parameter longint SYS_CLK_HZ = 100_000_000,
  parameter longint TICK_HZ    = 25_000_000,
  parameter int     FRAC_W     = 32,
  parameter int     DATA_W     = 32,
  parameter int     TIME_W     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [TIME_W-1:0] time_now
);
  localparam logic [FRAC_W+63:0] TICK_SCALED = (FRAC_W+64)'(TICK_HZ) << FRAC_W;
  localparam logic [FRAC_W+63:0] SYS_WIDE    = (FRAC_W+64)'(SYS_CLK_HZ);
  localparam logic [FRAC_W-1:0]  STEP_NOM    = FRAC_W'(TICK_SCALED / SYS_WIDE);

  logic [FRAC_W-1:0] step;
  logic [FRAC_W-1:0] phase;
  logic              carry;
  logic              load;
  logic [TIME_W-1:0] load_val;

  ptp_reg_port #(
    .DATA_W  (DATA_W),
    .FRAC_W  (FRAC_W),
    .TIME_W  (TIME_W),
    .STEP_RST(STEP_NOM)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .reg_addr(reg_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .time_in (time_now),
    .step    (step),
    .load    (load),
    .load_val(load_val),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  ptp_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .clear(load),
    .carry(carry),
    .phase(phase)
  );

  ptp_tick_counter #(.TIME_W(TIME_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .inc     (carry),
    .count   (time_now)
  );
endmodule

// File: rtl/ptp_frac_clock_chk.sv
module ptp_frac_clock_chk #(
  parameter int FRAC_W = 32,
  parameter int DATA_W = 32,
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [TIME_W-1:0] time_now,
  input logic [FRAC_W-1:0] step,
  input logic [FRAC_W-1:0] phase
);
  logic was_load;
  assign was_load = wr_en && (reg_addr == 2'd2);

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    !$past(was_load) |-> (TIME_W'(time_now - $past(time_now)) <= TIME_W'(1))); // R2

  AST_ZERO_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(was_load) && $past(step) == '0) |-> $stable(time_now)); // R3

  AST_LOAD_COMMITS_HIGH: assert property (@(posedge clk) disable iff (rst)
    was_load |=> (time_now[TIME_W-1 -: DATA_W] == $past(wr_data))); // R5

  AST_LOAD_CLEARS_PHASE: assert property (@(posedge clk) disable iff (rst)
    was_load |=> (phase == '0)); // R5

  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R8

  AST_RD_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R8

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(was_load) && $past(time_now) == '1 && time_now != '1) |-> (time_now == '0)); // R7
endmodule

bind ptp_frac_clock ptp_frac_clock_chk #(
  .FRAC_W(FRAC_W),
  .DATA_W(DATA_W),
  .TIME_W(TIME_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .reg_addr(reg_addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_valid(rd_valid),
  .time_now(time_now),
  .step    (step),
  .phase   (phase)
);

// File: tb/ptp_frac_clock_bench.sv
module ptp_frac_clock_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [63:0] time_now;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ptp_frac_clock u_ptp_frac_clock (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .time_now(time_now)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_time(input logic [63:0] base, input logic [31:0] stp, input int k);
    logic [63:0] prod;
    prod = 64'(k) * 64'(stp);
    return base + (prod >> 32);
  endfunction

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk("R8 unexpected read", 64'(rd_data), 64'hDEAD);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(rd_data), 64'(e));
      end
    end
  end

  // all driver tasks start and end at a falling edge and use one rising edge
  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [31:0] e, input string t);
    reg_addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    chk({"R8 valid ", t}, 64'(rd_valid), 64'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_time(input logic [63:0] v);
    reg_wr(2'd1, v[31:0]);
    reg_wr(2'd2, v[63:32]);
  endtask

  task automatic run_case(input logic [31:0] stp, input logic [63:0] base, input int n, input string t);
    logic [63:0] at_lo;
    reg_wr(2'd0, stp);
    load_time(base);
    idle(n);
    at_lo = exp_time(base, stp, n);
    reg_rd(2'd1, at_lo[31:0], {t, " low"});
    reg_rd(2'd2, at_lo[63:32], {t, " high R6"});
    chk({t, " bus R9"}, time_now, exp_time(base, stp, n + 2));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 time zero", time_now, 64'd0);
    chk("R1 valid low", 64'(rd_valid), 64'd0);
    reg_rd(2'd0, 32'h4000_0000, "R1 nominal step");

    run_case(32'h4000_0000, 64'h0000_0010_0000_0000, 10, "R2 quarter");
    run_case(32'h2AAA_AAAB, 64'h0000_0000_1234_5678, 20, "R2 sixth");
    run_case(32'h9000_0001, 64'h0000_0003_0000_0100, 37, "R2 odd");
    run_case(32'h0000_0000, 64'h0000_0042_0000_0007, 50, "R3 zero step");
    run_case(32'hFFFF_FFFF, 64'h0000_0001_0000_0000, 30, "R4 full step");
    run_case(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0, 15, "R7 wrap");
    chk("R7 wrapped to zero", time_now, 64'd0);
    run_case(32'h4000_0000, 64'hFF80_0000_0000_0000, 5, "R7 near rollover");
    // carry crosses bit 32 between the two reads
    run_case(32'hFFFF_FFFF, 64'h0000_0005_FFFF_FFFF, 1, "R6 coherent");
    chk("R6 live high moved", time_now, 64'h0000_0006_0000_0001);

    // R5: low-word write alone does not disturb the running count
    reg_wr(2'd0, 32'h4000_0000);
    load_time(64'h0000_0700_0000_0000);
    reg_wr(2'd1, 32'hABCD_0000);
    chk("R5 low write only", time_now, exp_time(64'h0000_0700_0000_0000, 32'h4000_0000, 1));
    idle(6);
    chk("R5 still running", time_now, exp_time(64'h0000_0700_0000_0000, 32'h4000_0000, 7));

    // R10: a step change keeps the accumulated phase
    reg_wr(2'd0, 32'h6000_0000);
    load_time(64'h0000_0000_0000_0900);
    reg_wr(2'd0, 32'hA000_0000);
    chk("R10 after write", time_now, 64'h0000_0000_0000_0900);
    idle(1);
    chk("R10 phase kept", time_now, 64'h0000_0000_0000_0901);
    reg_rd(2'd0, 32'hA000_0000, "R8 step readback");

    idle(2);
    chk("R8 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule